// File: doc/BRIEF.md
# Command Unlock Decoder

This block sits on the device side of a byte-wide parallel memory and watches every byte write the host issues. It looks for fixed address/data unlock patterns and, when one completes, changes the device mode. The patterns come in two lengths. The short form has three cycles. The long form has six cycles and is reached through an extension code in the third cycle.

The decoder keeps one global write-protection flag and a per-page unlock that the protected write command grants. Ordinary data writes are forwarded to the page buffer as a load strobe with address and data, or rejected with a drop strobe when protection blocks them. A chip-erase start pulse goes to the array sequencer. An identification mode replaces array read data with a maker code and a device code.

The page buffer reports the end of its load window through `page_close`, which withdraws the per-page unlock. Bytes that belong to a command pattern never reach the page buffer. A pattern broken part way returns the matcher to idle, and the breaking byte has no effect at all.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: While `rst` is high, and on the first clock edge after reset, the outputs are as follows: `prot_on`=0, `id_mode`=0, `page_permit`=1, and no load, drop or erase strobe is asserted.
- R2: With protection off, a write that is not part of a command pattern produces `load_stb` for exactly one cycle, one clock after the write. `load_addr` and `load_data` carry that write's address and data during that cycle.
- R3: The protected-write pattern sets `prot_on` and `page_permit` one clock after its last byte. The pattern is AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h. Later ordinary writes are loaded. Pattern bytes never raise `load_stb`.
- R4: With `prot_on`=1 and no page unlock, an ordinary write gives a one-cycle `drop_stb` and no `load_stb`.
- R5: `page_close` clears the page unlock, so `page_permit` goes to 0 while `prot_on` stays 1. A second protected-write pattern unlocks the next page, and `prot_on` stays 1.
- R6: A six-byte pattern clears `prot_on` one clock after its last byte. The pattern is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h. Ordinary writes are then loaded again.
- R7: The same six-byte prefix ending in 10h@5555h raises `erase_start` for exactly one cycle, one clock after the last byte, and leaves `prot_on` unchanged.
- R8: The three-byte pattern ending in 90h@5555h raises `id_mode` exactly ID_DLY clocks after its last byte. While `id_mode` is set, a read whose address bits 14..1 are zero returns BFh when bit 0 is 0 and DEV_CODE (07h) when bit 0 is 1. Every other read returns `arr_rd_data`.
- R9: The six-byte prefix ending in 60h@5555h also enters identification mode, with the same ID_DLY delay.
- R10: The three-byte pattern ending in F0h@5555h clears `id_mode` ID_DLY clocks after its last byte. Reads then return `arr_rd_data` again.
- R11: Only address bits 14..0 take part in pattern matching. Bits 16 and 15 may hold any value.
- R12: A byte that breaks a partly matched pattern returns the matcher to idle, and that byte produces neither a load nor a drop. A following lone A0h at 5555h is then an ordinary write.
- R13: Asserting `rst` leaves identification mode and clears protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe for a host byte write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| page_close | input | 1 | Page buffer load window has ended |
| rd_addr | input | 17 | Read address |
| arr_rd_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data returned to the host |
| prot_on | output | 1 | Global write protection is active |
| page_permit | output | 1 | Ordinary writes are currently accepted |
| load_stb | output | 1 | Forward one byte to the page buffer |
| load_addr | output | 17 | Address of the forwarded byte |
| load_data | output | 8 | Data of the forwarded byte |
| drop_stb | output | 1 | An ordinary write was rejected |
| erase_start | output | 1 | One-cycle chip-erase start pulse |
| id_mode | output | 1 | Identification read mode is active |

## Verification
The hardest state to reach from the ports is a broken pattern deep inside the sequence. The matcher must have consumed two valid unlock bytes, then receive a wrong third byte, and only the following write shows whether it really returned to idle. The stimulus table places a wrong third byte after a valid prefix and then sends a lone A0h at 5555h, which is loaded only if the matcher is idle. Ignored upper address bits are reached by running a full protected-write pattern with bits 16 and 15 set while protection is already on, where the only visible proof is that a later data byte is loaded instead of dropped.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int KEY_W  = 15;

    localparam logic [KEY_W-1:0] KEY_LO = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_HI = 15'h2AAA;

    localparam logic [DATA_W-1:0] UNLK_1     = 8'hAA;
    localparam logic [DATA_W-1:0] UNLK_2     = 8'h55;
    localparam logic [DATA_W-1:0] OP_PROT_WR = 8'hA0;
    localparam logic [DATA_W-1:0] OP_ID_IN   = 8'h90;
    localparam logic [DATA_W-1:0] OP_ID_OUT  = 8'hF0;
    localparam logic [DATA_W-1:0] OP_EXTEND  = 8'h80;
    localparam logic [DATA_W-1:0] OP_UNPROT  = 8'h20;
    localparam logic [DATA_W-1:0] OP_ERASE   = 8'h10;
    localparam logic [DATA_W-1:0] OP_ID_ALT  = 8'h60;
    localparam logic [DATA_W-1:0] ID_MAKER   = 8'hBF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_U1,
        SQ_U2,
        SQ_EXT,
        SQ_X1,
        SQ_X2
    } seq_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_PROT_WR,
        CMD_ID_IN,
        CMD_ID_OUT,
        CMD_UNPROT,
        CMD_ERASE
    } cmd_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic key_hit(input logic [KEY_W-1:0] a,
                                     input logic [KEY_W-1:0] k);
        return a == k;
    endfunction

    function automatic cmd_e decode_short(input logic [DATA_W-1:0] d);
        case (d)
            OP_PROT_WR: return CMD_PROT_WR;
            OP_ID_IN:   return CMD_ID_IN;
            OP_ID_OUT:  return CMD_ID_OUT;
            default:    return CMD_NONE;
        endcase
    endfunction

    function automatic cmd_e decode_long(input logic [DATA_W-1:0] d);
        case (d)
            OP_UNPROT: return CMD_UNPROT;
            OP_ERASE:  return CMD_ERASE;
            OP_ID_ALT: return CMD_ID_IN;
            default:   return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match
    import cmdseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_stb,
    input  bus_wr_t wr,
    output logic    consume,
    output cmd_e    cmd
);

    seq_e st, nxt;
    logic hit_lo, hit_hi;
    logic unused_fsm;

    assign unused_fsm = ^wr.addr[ADDR_W-1:KEY_W];
    assign hit_lo = key_hit(wr.addr[KEY_W-1:0], KEY_LO);
    assign hit_hi = key_hit(wr.addr[KEY_W-1:0], KEY_HI);

    always_comb begin
        nxt     = st;
        consume = 1'b0;
        cmd     = CMD_NONE;
        if (wr_stb) begin
            case (st)
                SQ_IDLE: begin
                    if (hit_lo && wr.data == UNLK_1) begin
                        nxt     = SQ_U1;
                        consume = 1'b1;
                    end
                end
                SQ_U1, SQ_X1: begin
                    consume = 1'b1;
                    if (hit_hi && wr.data == UNLK_2)
                        nxt = (st == SQ_U1) ? SQ_U2 : SQ_X2;
                    else
                        nxt = SQ_IDLE;
                end
                SQ_U2: begin
                    consume = 1'b1;
                    nxt     = SQ_IDLE;
                    if (hit_lo) begin
                        if (wr.data == OP_EXTEND)
                            nxt = SQ_EXT;
                        else
                            cmd = decode_short(wr.data);
                    end
                end
                SQ_EXT: begin
                    consume = 1'b1;
                    nxt     = (hit_lo && wr.data == UNLK_1) ? SQ_X1 : SQ_IDLE;
                end
                SQ_X2: begin
                    consume = 1'b1;
                    nxt     = SQ_IDLE;
                    if (hit_lo)
                        cmd = decode_long(wr.data);
                end
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= SQ_IDLE;
        else
            st <= nxt;
    end

endmodule

// File: rtl/cmdseq_guard.sv
module cmdseq_guard
    import cmdseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_stb,
    input  bus_wr_t wr,
    input  logic    consume,
    input  cmd_e    cmd,
    input  logic    page_close,
    output logic    prot_on,
    output logic    page_permit,
    output logic    load_stb,
    output bus_wr_t load_wr,
    output logic    drop_stb,
    output logic    erase_stb
);

    logic unlock;
    logic pass;
    logic open_gate;

    assign pass        = wr_stb && !consume;
    assign open_gate   = !prot_on || unlock;
    assign page_permit = open_gate;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_on   <= 1'b0;
            unlock    <= 1'b0;
            load_stb  <= 1'b0;
            drop_stb  <= 1'b0;
            erase_stb <= 1'b0;
            load_wr   <= '0;
        end else begin
            load_stb  <= pass && open_gate;
            drop_stb  <= pass && !open_gate;
            erase_stb <= (cmd == CMD_ERASE);
            if (pass && open_gate)
                load_wr <= wr;
            case (cmd)
                CMD_PROT_WR: begin
                    prot_on <= 1'b1;
                    unlock  <= 1'b1;
                end
                CMD_UNPROT: begin
                    prot_on <= 1'b0;
                    unlock  <= 1'b0;
                end
                default: begin
                    if (page_close)
                        unlock <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cmdseq_ident.sv
module cmdseq_ident
    import cmdseq_pkg::*;
#(
    parameter int                ID_DLY   = 4,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [KEY_W-1:0]  rd_key,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              id_mode
);

    localparam int CW = $clog2(ID_DLY + 1);

    logic [CW-1:0] cnt;
    logic          pend;
    logic          id_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pend    <= 1'b0;
            id_mode <= 1'b0;
        end else if (cmd == CMD_ID_IN || cmd == CMD_ID_OUT) begin
            cnt  <= CW'(ID_DLY);
            pend <= (cmd == CMD_ID_IN);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1))
                id_mode <= pend;
        end
    end

    assign id_hit  = id_mode && (rd_key[KEY_W-1:1] == '0);
    assign rd_data = id_hit ? (rd_key[0] ? DEV_CODE : ID_MAKER) : arr_rd_data;

endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder
    import cmdseq_pkg::*;
#(
    parameter int                ID_DLY   = 4,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              page_close,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              prot_on,
    output logic              page_permit,
    output logic              load_stb,
    output logic [ADDR_W-1:0] load_addr,
    output logic [DATA_W-1:0] load_data,
    output logic              drop_stb,
    output logic              erase_start,
    output logic              id_mode
);

    bus_wr_t wr_bus;
    bus_wr_t load_bus;
    logic    consume;
    cmd_e    cmd;
    logic    unused_rd_hi;

    assign wr_bus.addr  = wr_addr;
    assign wr_bus.data  = wr_data;
    assign load_addr    = load_bus.addr;
    assign load_data    = load_bus.data;
    assign unused_rd_hi = ^rd_addr[ADDR_W-1:KEY_W];

    cmdseq_match u_match (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr      (wr_bus),
        .consume (consume),
        .cmd     (cmd)
    );

    cmdseq_guard u_guard (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .wr          (wr_bus),
        .consume     (consume),
        .cmd         (cmd),
        .page_close  (page_close),
        .prot_on     (prot_on),
        .page_permit (page_permit),
        .load_stb    (load_stb),
        .load_wr     (load_bus),
        .drop_stb    (drop_stb),
        .erase_stb   (erase_start)
    );

    cmdseq_ident #(
        .ID_DLY   (ID_DLY),
        .DEV_CODE (DEV_CODE)
    ) u_ident (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .rd_key      (rd_addr[KEY_W-1:0]),
        .arr_rd_data (arr_rd_data),
        .rd_data     (rd_data),
        .id_mode     (id_mode)
    );

endmodule

// File: rtl/cmd_unlock_decoder_chk.sv
module cmd_unlock_decoder_chk (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic prot_on,
    input logic page_permit,
    input logic load_stb,
    input logic drop_stb,
    input logic erase_start,
    input logic id_mode
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!prot_on && !id_mode && !load_stb && !drop_stb && !erase_start && page_permit));

    assert_load_from_write_R2: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> $past(wr_stb));

    assert_prot_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_on) |-> ($past(wr_stb) && page_permit));

    assert_drop_locked_R4: assert property (@(posedge clk) disable iff (rst)
        drop_stb |-> ($past(prot_on) && !load_stb));

    assert_prot_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_on) |-> $past(wr_stb));

    assert_erase_single_R7: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

endmodule

bind cmd_unlock_decoder cmd_unlock_decoder_chk u_chk (.*);

// File: tb/cmd_unlock_decoder_test.sv
module cmd_unlock_decoder_test;

    localparam int DLY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_close = 1'b0;
    logic [16:0] rd_addr = '0;
    logic [7:0]  arr_rd_data = '0;
    logic [7:0]  rd_data;
    logic        prot_on, page_permit, load_stb, drop_stb, erase_start, id_mode;
    logic [16:0] load_addr;
    logic [7:0]  load_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cmd_unlock_decoder #(.ID_DLY(DLY), .DEV_CODE(8'h07)) uut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .page_close(page_close), .rd_addr(rd_addr), .arr_rd_data(arr_rd_data),
        .rd_data(rd_data), .prot_on(prot_on), .page_permit(page_permit),
        .load_stb(load_stb), .load_addr(load_addr), .load_data(load_data),
        .drop_stb(drop_stb), .erase_start(erase_start), .id_mode(id_mode)
    );

    // {close_before, exp_load, exp_drop, exp_prot, addr[16:0], data[7:0]}
    localparam int NV = 22;
    localparam logic [28:0] VEC [NV] = '{
        {4'b0100, 17'h00123, 8'h5A},  // R2 plain load
        {4'b0000, 17'h05555, 8'hAA},  // R3
        {4'b0000, 17'h02AAA, 8'h55},
        {4'b0001, 17'h05555, 8'hA0},  // R3 protect on
        {4'b0101, 17'h00200, 8'h11},
        {4'b0101, 17'h00201, 8'h22},
        {4'b1011, 17'h00300, 8'h33},  // R4 R5 dropped after close
        {4'b0001, 17'h15555, 8'hAA},  // R11 high bits set
        {4'b0001, 17'h0AAAA, 8'h55},
        {4'b0001, 17'h15555, 8'hA0},
        {4'b0101, 17'h00310, 8'h44},  // R5 R11 next page unlocked
        {4'b1001, 17'h05555, 8'hAA},  // R6
        {4'b0001, 17'h02AAA, 8'h55},
        {4'b0001, 17'h05555, 8'h80},
        {4'b0001, 17'h05555, 8'hAA},
        {4'b0001, 17'h02AAA, 8'h55},
        {4'b0000, 17'h05555, 8'h20},  // R6 protect off
        {4'b0100, 17'h00400, 8'h66},
        {4'b0000, 17'h05555, 8'hAA},  // R12
        {4'b0000, 17'h02AAA, 8'h55},
        {4'b0000, 17'h05555, 8'h33},  // R12 broken, no load no drop
        {4'b0100, 17'h05555, 8'hA0}   // R12 idle again, plain load
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic close_page();
        @(negedge clk);
        page_close = 1'b1;
        @(negedge clk);
        page_close = 1'b0;
    endtask

    task automatic cmd3(input logic [7:0] op);
        write_byte(17'h05555, 8'hAA);
        write_byte(17'h02AAA, 8'h55);
        write_byte(17'h05555, op);
    endtask

    task automatic cmd6(input logic [7:0] op);
        cmd3(8'h80);
        cmd3(op);
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        wait_clk(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 prot_on", prot_on, 0);
        check("R1 id_mode", id_mode, 0);
        check("R1 page_permit", page_permit, 1);
        check("R1 strobes", {load_stb, drop_stb, erase_start}, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("table step %0d (R2 R3 R4 R5 R6 R11 R12)", i);
            if (VEC[i][28]) close_page();
            write_byte(VEC[i][24:8], VEC[i][7:0]);
            check({tag, " load"}, load_stb, VEC[i][27]);
            check({tag, " drop"}, drop_stb, VEC[i][26]);
            check({tag, " prot"}, prot_on, VEC[i][25]);
            if (VEC[i][27]) begin
                check({tag, " addr"}, load_addr, VEC[i][24:8]);
                check({tag, " data"}, load_data, VEC[i][7:0]);
            end
        end

        // R7 chip erase pulse
        cmd6(8'h10);
        check("R7 erase pulse", erase_start, 1);
        check("R7 prot unchanged", prot_on, 0);
        @(negedge clk);
        check("R7 erase single cycle", erase_start, 0);

        // R8 ID entry
        cmd3(8'h90);
        wait_clk(DLY - 1);
        check("R8 id not yet", id_mode, 0);
        @(negedge clk);
        check("R8 id entered", id_mode, 1);
        arr_rd_data = 8'hC3;
        rd_addr = 17'h00000; #1;
        check("R8 maker code", rd_data, 8'hBF);
        rd_addr = 17'h00001; #1;
        check("R8 device code", rd_data, 8'h07);
        rd_addr = 17'h18000; #1;
        check("R8 upper bits ignored", rd_data, 8'hBF);
        rd_addr = 17'h00002; #1;
        check("R8 other address", rd_data, 8'hC3);

        // R10 ID exit
        cmd3(8'hF0);
        wait_clk(DLY - 1);
        check("R10 id still set", id_mode, 1);
        @(negedge clk);
        check("R10 id left", id_mode, 0);
        rd_addr = 17'h00000; #1;
        check("R10 array read", rd_data, 8'hC3);

        // R9 alternate ID entry
        cmd6(8'h60);
        wait_clk(DLY);
        check("R9 alt id entered", id_mode, 1);

        // R5 permit withdrawn by close
        cmd3(8'hA0);
        check("R5 permit after unlock", page_permit, 1);
        close_page();
        check("R5 permit closed", page_permit, 0);
        check("R5 prot kept", prot_on, 1);

        // R13 reset clears modes
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R13 id cleared", id_mode, 0);
        check("R13 prot cleared", prot_on, 0);
        check("R13 permit", page_permit, 1);

        finish_run();
    end

endmodule